// File: doc/BRIEF.md
# Descriptor Ring DMA Channel

This block is one direction of a packet DMA engine. It owns a small local RAM holding a circular ring of descriptors, each a pair of 32-bit words: a buffer address and a control word. Software fills in a descriptor and hands it to the engine by setting the ownership bit. The engine visits descriptors strictly in ring order. For each one it moves bytes between a byte-wide stream and a modelled buffer memory. It then writes the control word back with ownership returned and the completion flag raised, and raises an interrupt.

A static mode input selects the direction. In receive mode the engine fills the buffer from the inbound stream, starting at the address plus the offset field, and reports how many bytes it stored. In transmit mode it reads the buffer from the address plus the offset field and drives the outbound stream. This lets software pass a burst-aligned address and keep the misalignment in the offset. A frame longer than a receive buffer spills into the following descriptors. The start-of-packet and end-of-packet flags mark where the frame begins and ends.

Top module: `dma_ring_chan`

## Requirements
- R1: After reset, `irq`, `rx_ready`, `tx_valid` and `buf_we` are all 0.
- R2: When the descriptor at the current ring position has its ownership bit (control bit 31) clear, the engine stays on it: it accepts no stream data, drives no stream data and writes nothing. It resumes once software sets the bit.
- R3: In receive mode, byte k of the frame (counting from 0) is written to buffer address `addr + offset + k`. Here `addr` is the address word and `offset` is control bits 27:23.
- R4: A receive write-back sets the control word as follows: bit 31 (ownership) = 0, bit 30 (complete) = 1, bit 29 (start-of-packet) = 1 if the descriptor holds the first byte of a frame, bit 28 (end-of-packet) = 1 if it holds the last byte. The offset field is kept. Bits 15:0 hold the number of bytes stored, counting every byte the stream delivered, trailing CRC included.
- R5: In receive mode, bits 15:0 of the posted control word give the buffer size. When a frame fills the buffer before its last byte, the descriptor closes with end-of-packet 0 and length equal to the size. The rest of the frame continues in the next descriptor with start-of-packet 0.
- R6: In transmit mode, the engine emits exactly `length` bytes (bits 15:0), read in order from `addr + offset`. `tx_last` is high with the final byte only when end-of-packet (bit 28) is set in the posted descriptor.
- R7: A transmit write-back clears ownership and sets complete. It keeps every other control bit and the address word unchanged.
- R8: After each write-back, the ring position advances by one and wraps from the last entry to entry 0.
- R9: Each write-back sets `irq`. `irq` stays high until an `irq_ack` pulse clears it.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R11: While `chan_en` is low, no descriptor is started, even one that is owned by the engine, and the descriptor stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_mode | input | 1 | 1 = transmit channel, 0 = receive channel (change only while idle) |
| chan_en | input | 1 | Permits the engine to start descriptors |
| sw_we | input | 1 | Software write strobe into descriptor RAM |
| sw_idx | input | IDX_W (2) | Descriptor index for software access |
| sw_word | input | 1 | 0 selects the address word, 1 the control word |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Selected descriptor word (combinational) |
| rx_valid | input | 1 | Inbound byte valid |
| rx_data | input | 8 | Inbound byte |
| rx_last | input | 1 | Inbound byte ends the frame |
| rx_ready | output | 1 | Engine accepts an inbound byte |
| tx_valid | output | 1 | Outbound byte valid |
| tx_data | output | 8 | Outbound byte |
| tx_last | output | 1 | Outbound byte ends the frame |
| tx_ready | input | 1 | Sink accepts the outbound byte |
| buf_we | output | 1 | Buffer memory write strobe |
| buf_addr | output | BUF_AW (12) | Buffer memory byte address |
| buf_wdata | output | 8 | Buffer memory write data |
| buf_rdata | input | 8 | Buffer memory read data (combinational) |
| irq | output | 1 | Completion interrupt, level |
| irq_ack | input | 1 | Clears the interrupt |

## Verification
Receive mode is tried with three patterns. The first is a single 64-byte frame that fits one buffer, which exposes length and offset placement errors. The second is a 12-byte frame split across an 8-byte buffer and a large one, which separates the correct start/end flag hand-over from a design that restarts or truncates frames. The third is an unowned or disabled descriptor with stream data waiting, which shows whether the engine stalls or runs ahead. Transmit mode is tried with a non-zero offset and a sink that withholds `tx_ready` in a repeating pattern, which distinguishes correct byte ordering and holding from dropped or repeated bytes. A final transmit on the last-to-first ring step shows whether the position wraps rather than overruns.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
    localparam int OWN_BIT = 31;
    localparam int CPL_BIT = 30;
    localparam int SOP_BIT = 29;
    localparam int EOP_BIT = 28;
    localparam int OFS_LSB = 23;
    localparam int OFS_W   = 5;
    localparam int LEN_W   = 16;
    localparam int WORD_W  = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MOVE  = 2'd1,
        ST_WBACK = 2'd2
    } eng_st_e;
endpackage

// File: rtl/dma_desc_ram.sv
module dma_desc_ram
    import dma_ring_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic              sw_word,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] sw_rdata,
    input  logic [IDX_W-1:0]  eng_idx,
    output logic [WORD_W-1:0] eng_addr,
    output logic [WORD_W-1:0] eng_ctl,
    input  logic              wb_we,
    input  logic [WORD_W-1:0] wb_ctl
);
    logic [WORD_W-1:0] addr_q [DEPTH];
    logic [WORD_W-1:0] ctl_q  [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic [WORD_W-1:0] addr_d, ctl_d;
        logic sw_hit, wb_hit;

        always_comb begin
            sw_hit = sw_we && (sw_idx == IDX_W'(i));
            wb_hit = wb_we && (eng_idx == IDX_W'(i));
            addr_d = addr_q[i];
            ctl_d  = ctl_q[i];
            if (sw_hit && !sw_word) addr_d = sw_wdata;
            if (sw_hit && sw_word)  ctl_d  = sw_wdata;
            // engine write-back wins a collision on the control word
            if (wb_hit)             ctl_d  = wb_ctl;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[i] <= '0;
                ctl_q[i]  <= '0;
            end else begin
                addr_q[i] <= addr_d;
                ctl_q[i]  <= ctl_d;
            end
        end

        p_wb_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_we && eng_idx == IDX_W'(i)) |=> (!ctl_q[i][OWN_BIT] && ctl_q[i][CPL_BIT]));
    end

    assign sw_rdata = sw_word ? ctl_q[sw_idx] : addr_q[sw_idx];
    assign eng_addr = addr_q[eng_idx];
    assign eng_ctl  = ctl_q[eng_idx];
endmodule

// File: rtl/dma_irq_flag.sv
module dma_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (ack) irq_d = 1'b0;
        if (set) irq_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> irq);
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);
endmodule

// File: rtl/dma_ring_engine.sv
module dma_ring_engine
    import dma_ring_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int BUF_AW = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_mode,
    input  logic              chan_en,
    input  logic [WORD_W-1:0] cur_addr,
    input  logic [WORD_W-1:0] cur_ctl,
    output logic [IDX_W-1:0]  hw_idx,
    output logic              wb_we,
    output logic [WORD_W-1:0] wb_ctl,
    output logic              irq_set,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata
);
    typedef struct packed {
        eng_st_e           st;
        logic [IDX_W-1:0]  idx;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  lim;
        logic [BUF_AW-1:0] base;
        logic [OFS_W-1:0]  ofs;
        logic              eop_in;
        logic              sop_pend;
        logic              eop_out;
    } eng_s;

    eng_s r_d, r_q;
    logic [LEN_W-1:0] cnt_inc;
    logic             last_slot;

    always_comb begin
        r_d       = r_q;
        rx_ready  = 1'b0;
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        buf_we    = 1'b0;
        wb_we     = 1'b0;
        irq_set   = 1'b0;
        wb_ctl    = cur_ctl;
        cnt_inc   = r_q.cnt + LEN_W'(1);
        last_slot = (cnt_inc == r_q.lim);
        buf_addr  = r_q.base + BUF_AW'(r_q.ofs) + BUF_AW'(r_q.cnt);
        buf_wdata = rx_data;

        unique case (r_q.st)
            ST_IDLE: begin
                if (chan_en && cur_ctl[OWN_BIT]) begin
                    r_d.base    = cur_addr[BUF_AW-1:0];
                    r_d.ofs     = cur_ctl[OFS_LSB +: OFS_W];
                    r_d.lim     = cur_ctl[LEN_W-1:0];
                    r_d.eop_in  = cur_ctl[EOP_BIT];
                    r_d.cnt     = '0;
                    r_d.eop_out = 1'b0;
                    r_d.st      = (cur_ctl[LEN_W-1:0] == '0) ? ST_WBACK : ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (tx_mode) begin
                    tx_valid = 1'b1;
                    tx_last  = r_q.eop_in && last_slot;
                    if (tx_ready) begin
                        r_d.cnt = cnt_inc;
                        if (last_slot) r_d.st = ST_WBACK;
                    end
                end else begin
                    rx_ready = 1'b1;
                    if (rx_valid) begin
                        buf_we  = 1'b1;
                        r_d.cnt = cnt_inc;
                        if (rx_last) begin
                            r_d.eop_out = 1'b1;
                            r_d.st      = ST_WBACK;
                        end else if (last_slot) begin
                            r_d.eop_out = 1'b0;
                            r_d.st      = ST_WBACK;
                        end
                    end
                end
            end
            ST_WBACK: begin
                wb_we            = 1'b1;
                irq_set          = 1'b1;
                wb_ctl[OWN_BIT]  = 1'b0;
                wb_ctl[CPL_BIT]  = 1'b1;
                if (!tx_mode) begin
                    wb_ctl[SOP_BIT]     = r_q.sop_pend;
                    wb_ctl[EOP_BIT]     = r_q.eop_out;
                    wb_ctl[LEN_W-1:0]   = r_q.cnt;
                    r_d.sop_pend        = r_q.eop_out;
                end
                r_d.idx = (r_q.idx == IDX_W'(DEPTH - 1)) ? '0 : r_q.idx + IDX_W'(1);
                r_d.st  = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.sop_pend <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign hw_idx = r_q.idx;

    p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !cur_ctl[OWN_BIT]) |=> (r_q.st == ST_IDLE));
    p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !chan_en) |=> (r_q.st == ST_IDLE));
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MOVE) |-> (r_q.cnt < r_q.lim));
    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(buf_addr)));
    p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WBACK) |=>
        (r_q.idx == (($past(r_q.idx) == IDX_W'(DEPTH - 1)) ? '0 : $past(r_q.idx) + IDX_W'(1))));
endmodule

// File: rtl/dma_ring_chan.sv
module dma_ring_chan
    import dma_ring_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int BUF_AW = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_mode,
    input  logic              chan_en,
    input  logic              sw_we,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic              sw_word,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata,
    output logic              irq,
    input  logic              irq_ack
);
    logic [IDX_W-1:0]  hw_idx;
    logic [WORD_W-1:0] cur_addr, cur_ctl, wb_ctl;
    logic              wb_we, irq_set;

    dma_desc_ram #(.DEPTH(DEPTH)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (sw_we),
        .sw_idx   (sw_idx),
        .sw_word  (sw_word),
        .sw_wdata (sw_wdata),
        .sw_rdata (sw_rdata),
        .eng_idx  (hw_idx),
        .eng_addr (cur_addr),
        .eng_ctl  (cur_ctl),
        .wb_we    (wb_we),
        .wb_ctl   (wb_ctl)
    );

    dma_ring_engine #(.DEPTH(DEPTH), .BUF_AW(BUF_AW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_mode   (tx_mode),
        .chan_en   (chan_en),
        .cur_addr  (cur_addr),
        .cur_ctl   (cur_ctl),
        .hw_idx    (hw_idx),
        .wb_we     (wb_we),
        .wb_ctl    (wb_ctl),
        .irq_set   (irq_set),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_last   (rx_last),
        .rx_ready  (rx_ready),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_wdata (buf_wdata)
    );

    dma_irq_flag u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .ack   (irq_ack),
        .irq   (irq)
    );

    assign tx_data = buf_rdata;

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq && !rx_ready && !tx_valid && !buf_we));
endmodule

// File: tb/tb_dma_ring_chan.sv
`timescale 1ns/1ps
module tb_dma_ring_chan;
    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] CPL = 32'h4000_0000;
    localparam logic [31:0] SOP = 32'h2000_0000;
    localparam logic [31:0] EOP = 32'h1000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_mode = 1'b0, chan_en = 1'b0;
    logic sw_we = 1'b0, sw_word = 1'b0;
    logic [1:0] sw_idx = '0;
    logic [31:0] sw_wdata = '0, sw_rdata;
    logic rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
    logic [7:0] rx_data = '0;
    logic tx_valid, tx_last, tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic buf_we;
    logic [11:0] buf_addr;
    logic [7:0] buf_wdata, buf_rdata;
    logic irq, irq_ack = 1'b0;

    logic [7:0] mem [0:4095];
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_ring_chan dut (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .chan_en(chan_en),
        .sw_we(sw_we), .sw_idx(sw_idx), .sw_word(sw_word), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .irq(irq), .irq_ack(irq_ack)
    );

    assign buf_rdata = mem[buf_addr];
    always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sw_write(input int idx, input bit word, input logic [31:0] val);
        @(negedge clk);
        sw_we = 1'b1; sw_idx = 2'(idx); sw_word = word; sw_wdata = val;
        @(posedge clk); #1;
        sw_we = 1'b0;
    endtask

    task automatic sw_read(input int idx, input bit word, output logic [31:0] val);
        sw_idx = 2'(idx); sw_word = word; #1;
        val = sw_rdata;
    endtask

    task automatic wait_free(input int idx);
        logic [31:0] v;
        for (int k = 0; k < 400; k++) begin
            sw_read(idx, 1'b1, v);
            if (!v[31] && v[30]) break;
            @(posedge clk); #1;
        end
    endtask

    task automatic send_rx(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1; rx_data = 8'(seed + i * 3); rx_last = (i == n - 1);
            for (int g = 0; g < 200 && !rx_ready; g++) begin @(posedge clk); #1; end
            @(posedge clk); #1;
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic ack_irq(input string req);
        @(negedge clk); irq_ack = 1'b1;
        @(posedge clk); #1; irq_ack = 1'b0;
        check(irq == 1'b0, req, {31'b0, irq}, 32'h0);
    endtask

    // collects n outbound bytes from base, with a stalling sink
    task automatic collect_tx(input int n, input int base, input bit stall, input string req);
        int got = 0, lasts = 0, bad = 0, holdbad = 0;
        bit prev_stall = 1'b0;
        logic [7:0] held = '0;
        for (int c = 0; c < 300 && got < n; c++) begin
            @(negedge clk);
            if (prev_stall && (!tx_valid || tx_data != held)) holdbad++;
            tx_ready = stall ? (c % 3 != 1) : 1'b1;
            if (tx_valid && tx_ready) begin
                if (tx_data != mem[base + got]) bad++;
                if (tx_last) begin
                    lasts++;
                    if (got != n - 1) bad++;
                end
                got++;
            end
            prev_stall = tx_valid && !tx_ready;
            held = tx_data;
        end
        @(negedge clk); tx_ready = 1'b0;
        check(got == n, {req, " byte count"}, 32'(got), 32'(n));
        check(bad == 0, {req, " data/last order"}, 32'(bad), 32'h0);
        check(lasts == 1, {req, " single tx_last"}, 32'(lasts), 32'h1);
        check(holdbad == 0, "R10 hold under backpressure", 32'(holdbad), 32'h0);
    endtask

    task automatic t_reset();
        check(irq == 1'b0 && rx_ready == 1'b0 && tx_valid == 1'b0 && buf_we == 1'b0,
              "R1 reset outputs", {28'b0, irq, rx_ready, tx_valid, buf_we}, 32'h0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        int seen = 0;
        sw_write(0, 1'b0, 32'h100);
        sw_write(0, 1'b1, OWN | (32'd2 << 23) | 32'h600);
        rx_valid = 1'b1; rx_data = 8'h55;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (rx_ready || buf_we) seen++;
        end
        rx_valid = 1'b0;
        check(seen == 0, "R11 disabled channel idle", 32'(seen), 32'h0);
        sw_read(0, 1'b1, v);
        check(v == (OWN | (32'd2 << 23) | 32'h600), "R11 descriptor untouched", v, OWN | (32'd2 << 23) | 32'h600);
    endtask

    task automatic t_rx_single();
        logic [31:0] v;
        int bad = 0;
        chan_en = 1'b1;
        send_rx(64, 1);
        wait_free(0);
        sw_read(0, 1'b1, v);
        check(v == (CPL | SOP | EOP | (32'd2 << 23) | 32'd64), "R4 rx write-back", v,
              CPL | SOP | EOP | (32'd2 << 23) | 32'd64);
        for (int i = 0; i < 64; i++) if (mem[12'h102 + i] != 8'(1 + i * 3)) bad++;
        check(bad == 0, "R3 rx placement", 32'(bad), 32'h0);
        repeat (3) @(posedge clk); #1;
        check(irq == 1'b1, "R9 irq held", {31'b0, irq}, 32'h1);
        ack_irq("R9 irq cleared by ack");
    endtask

    task automatic t_rx_split();
        logic [31:0] v;
        int seen = 0, bad = 0;
        // position 1 is not owned: stream must wait
        rx_valid = 1'b1; rx_data = 8'hAA;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (rx_ready || buf_we) seen++;
        end
        rx_valid = 1'b0;
        check(seen == 0, "R2 stall on unowned", 32'(seen), 32'h0);
        sw_write(1, 1'b0, 32'h300);
        sw_write(2, 1'b0, 32'h400);
        sw_write(2, 1'b1, OWN | (32'd2 << 23) | 32'h600);
        sw_write(1, 1'b1, OWN | (32'd2 << 23) | 32'd8);
        send_rx(12, 16);
        wait_free(2);
        sw_read(1, 1'b1, v);
        check(v == (CPL | SOP | (32'd2 << 23) | 32'd8), "R5 first part closes full", v,
              CPL | SOP | (32'd2 << 23) | 32'd8);
        sw_read(2, 1'b1, v);
        check(v == (CPL | EOP | (32'd2 << 23) | 32'd4), "R5 tail part", v,
              CPL | EOP | (32'd2 << 23) | 32'd4);
        for (int i = 0; i < 8; i++) if (mem[12'h302 + i] != 8'(16 + i * 3)) bad++;
        for (int i = 0; i < 4; i++) if (mem[12'h402 + i] != 8'(16 + (i + 8) * 3)) bad++;
        check(bad == 0, "R5 split placement", 32'(bad), 32'h0);
        ack_irq("R9 ack after split");
    endtask

    task automatic t_tx_offset();
        logic [31:0] v;
        tx_mode = 1'b1;
        for (int i = 0; i < 16; i++) mem[12'h500 + i] = 8'(8'hA0 + i);
        sw_write(3, 1'b0, 32'h500);
        sw_write(3, 1'b1, OWN | SOP | EOP | (32'd3 << 23) | 32'd10);
        collect_tx(10, 12'h503, 1'b1, "R6 tx offset");
        wait_free(3);
        sw_read(3, 1'b1, v);
        check(v == (CPL | SOP | EOP | (32'd3 << 23) | 32'd10), "R7 tx write-back", v,
              CPL | SOP | EOP | (32'd3 << 23) | 32'd10);
        sw_read(3, 1'b0, v);
        check(v == 32'h500, "R7 address kept", v, 32'h500);
        check(irq == 1'b1, "R9 tx irq", {31'b0, irq}, 32'h1);
        ack_irq("R9 tx ack");
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        for (int i = 0; i < 5; i++) mem[12'h600 + i] = 8'(8'h50 + i);
        sw_write(0, 1'b0, 32'h600);
        sw_write(0, 1'b1, OWN | SOP | EOP | 32'd5);
        collect_tx(5, 12'h600, 1'b0, "R8 wrap to entry 0");
        wait_free(0);
        sw_read(0, 1'b1, v);
        check(v == (CPL | SOP | EOP | 32'd5), "R8 entry 0 served after wrap", v, CPL | SOP | EOP | 32'd5);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_disabled();
        t_rx_single();
        t_rx_split();
        t_tx_offset();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule